// File: doc/BRIEF.md
# Two-Wide Fetch Branch Predictor

This block sits beside the fetch stage and predicts each two-instruction fetch group in the same cycle. The fetch stage gives it the word address of the group and the 3-bit opcode field of each slot. The block returns whether the group ends in a predicted-taken branch, the predicted target, whether one or two instructions go forward, and the next fetch address. A table of 2-bit saturating counters, indexed by the low bits of the instruction word address, supplies the direction. A small fully associative branch target buffer (BTB) with least-recently-used replacement supplies the target. A slot predicts taken only when both agree.

When the execution core resolves a branch, it presents the branch address, the actual direction and the 16-bit offset on the update port. The matching counter steps one state toward the outcome. The branch is written into the BTB whether or not it was taken, and it becomes the most recently used entry there. Squashing after a misprediction is the job of other logic.

Top module: `branch_pred_unit`

## Requirements
- R1: After reset every counter is weak not-taken (encoding 01) and the BTB is empty, so no group predicts taken until updates arrive.
- R2: Each counter has four states, encoded 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. Codes 10 and 11 mean taken. Each update moves the counter one step toward the outcome and saturates at 00 and 11.
- R3: The counter is selected by the low 6 bits of the word address, so two addresses with equal low 6 bits share one counter.
- R4: Every update, taken or not, writes the branch into the 3-entry BTB with target update address + 1 + sign-extended 16-bit offset, truncated to the address width. An address already present is rewritten in place.
- R5: When the BTB is full, a new branch replaces the entry least recently written by an update. Lookups do not change that order.
- R6: A slot predicts taken only when its opcode is 100 (branch), its counter is in a taken state and its address hits in the BTB. The predicted target is then the stored BTB target. pred_target is zero when nothing is predicted taken.
- R7: A branch in slot 0 that predicts taken forwards one instruction (fwd_two=0), and next_pc is its target.
- R8: When both slots hold branches, only slot 0 is forwarded (fwd_two=0). Unless slot 0 predicts taken, next_pc is fetch_pc + 1.
- R9: If the group is not trimmed, both instructions are forwarded (fwd_two=1). next_pc is the slot-1 target when slot 1 predicts taken, and fetch_pc + 2 otherwise.
- R10: A lookup in the same cycle as an update of its counter or BTB entry sees the state from before that update.
- R11: A group with no branch opcode in either slot never predicts taken and always forwards both instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 16 | Word address of slot 0 of the fetch group |
| slot0_op | input | 3 | Opcode field of slot 0 |
| slot1_op | input | 3 | Opcode field of slot 1 |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 16 | Word address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_offset | input | 16 | Signed branch offset of the resolved branch |
| pred_taken | output | 1 | The last forwarded slot is predicted taken |
| pred_target | output | 16 | Predicted target, zero when not taken |
| fwd_two | output | 1 | 1: forward both slots, 0: forward slot 0 only |
| next_pc | output | 16 | Next fetch word address |

## Verification
Direction tests train one branch up and down across its whole counter range, so a counter that fails to saturate or steps two states at once gives a wrong prediction. Aliasing addresses separate a counter hit from a BTB hit: one trained address makes its untrained alias fall on a taken counter that has no BTB entry. A sequence of four and then five distinct branches, with repeated lookups in between, shows whether the victim follows update order alone. Groups are tried with a branch in slot 0 only, in slot 1 only, in both slots and in neither. A negative offset and a lookup made in the same cycle as its own update cover target arithmetic and read-before-write timing.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_TK   = 2'b10,
      CTR_STRONG_TK = 2'b11
   } ctr_t;

   localparam logic [2:0] OP_BRANCH = 3'b100;

   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t res;
      case (cur)
         CTR_STRONG_NT: res = taken ? CTR_WEAK_NT   : CTR_STRONG_NT;
         CTR_WEAK_NT:   res = taken ? CTR_WEAK_TK   : CTR_STRONG_NT;
         CTR_WEAK_TK:   res = taken ? CTR_STRONG_TK : CTR_WEAK_NT;
         default:       res = taken ? CTR_STRONG_TK : CTR_WEAK_TK;
      endcase
      return res;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t c);
      return (c == CTR_WEAK_TK) || (c == CTR_STRONG_TK);
   endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken,
   output ctr_t             rd_ctr_a,
   output ctr_t             rd_ctr_b
);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("bp_ctr_table: ENTRIES must be a power of two, at least 2");
   end

   ctr_t cells [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)
            cells[e] <= CTR_WEAK_NT;
         else if (wr_en && wr_idx == IDX_W'(e))
            cells[e] <= ctr_next(cells[e], wr_taken);
      end
   end

   assign rd_ctr_a = cells[rd_idx_a];
   assign rd_ctr_b = cells[rd_idx_b];

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
   parameter int ENTRIES = 3,
   parameter int PC_W    = 16,
   localparam int AGE_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int SEL_W  = AGE_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] look_pc_a,
   input  logic [PC_W-1:0] look_pc_b,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target,
   output logic            hit_a,
   output logic [PC_W-1:0] tgt_a,
   output logic            hit_b,
   output logic [PC_W-1:0] tgt_b
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("bp_target_buffer: ENTRIES must be at least 2");
   end

   logic             vld  [ENTRIES];
   logic [PC_W-1:0]  tag  [ENTRIES];
   logic [PC_W-1:0]  dest [ENTRIES];
   logic [AGE_W-1:0] age  [ENTRIES];

   always_comb begin
      hit_a = 1'b0;
      tgt_a = '0;
      hit_b = 1'b0;
      tgt_b = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (vld[i] && tag[i] == look_pc_a) begin
            hit_a = 1'b1;
            tgt_a = dest[i];
         end
         if (vld[i] && tag[i] == look_pc_b) begin
            hit_b = 1'b1;
            tgt_b = dest[i];
         end
      end
   end

   logic             wr_hit;
   logic [SEL_W-1:0] hit_sel;
   logic [SEL_W-1:0] lru_sel;
   logic [SEL_W-1:0] sel;

   always_comb begin
      wr_hit  = 1'b0;
      hit_sel = '0;
      lru_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (vld[i] && tag[i] == wr_pc) begin
            wr_hit  = 1'b1;
            hit_sel = SEL_W'(i);
         end
         if (age[i] == AGE_W'(ENTRIES - 1))
            lru_sel = SEL_W'(i);
      end
      sel = wr_hit ? hit_sel : lru_sel;
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_way
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[e]  <= 1'b0;
            tag[e]  <= '0;
            dest[e] <= '0;
            age[e]  <= AGE_W'(ENTRIES - 1 - e);
         end else if (wr_en) begin
            if (sel == SEL_W'(e)) begin
               vld[e]  <= 1'b1;
               tag[e]  <= wr_pc;
               dest[e] <= wr_target;
               age[e]  <= '0;
            end else if (age[e] < age[sel]) begin
               age[e]  <= age[e] + AGE_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bp_group_trim.sv
module bp_group_trim #(
   parameter int PC_W         = 16,
   parameter bit PAIR_BR_TRIM = 1'b1
) (
   input  logic [PC_W-1:0] pc,
   input  logic            br0,
   input  logic            br1,
   input  logic            tk0,
   input  logic            tk1,
   input  logic [PC_W-1:0] tgt0,
   input  logic [PC_W-1:0] tgt1,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_target,
   output logic            fwd_two,
   output logic [PC_W-1:0] next_pc
);

   logic pair_cut;

   if (PAIR_BR_TRIM) begin : g_pair_cut
      assign pair_cut = br0 & br1;
   end else begin : g_no_pair_cut
      logic unused_br;
      assign unused_br = br0 ^ br1;
      assign pair_cut  = 1'b0;
   end

   always_comb begin
      if (tk0 || pair_cut) begin
         fwd_two     = 1'b0;
         pred_taken  = tk0;
         pred_target = tk0 ? tgt0 : '0;
         next_pc     = tk0 ? tgt0 : pc + PC_W'(1);
      end else begin
         fwd_two     = 1'b1;
         pred_taken  = tk1;
         pred_target = tk1 ? tgt1 : '0;
         next_pc     = tk1 ? tgt1 : pc + PC_W'(2);
      end
   end

endmodule

// File: rtl/branch_pred_unit.sv
module branch_pred_unit
   import bp_pkg::*;
#(
   parameter int PC_W         = 16,
   parameter int OFFS_W       = 16,
   parameter int CTR_ENTRIES  = 64,
   parameter int BTB_ENTRIES  = 3,
   parameter bit PAIR_BR_TRIM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   fetch_pc,
   input  logic [2:0]        slot0_op,
   input  logic [2:0]        slot1_op,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken,
   input  logic [OFFS_W-1:0] upd_offset,
   output logic              pred_taken,
   output logic [PC_W-1:0]   pred_target,
   output logic              fwd_two,
   output logic [PC_W-1:0]   next_pc
);

   localparam int IDX_W = $clog2(CTR_ENTRIES);

   if (PC_W < OFFS_W || PC_W <= IDX_W) begin : g_bad_widths
      $error("branch_pred_unit: PC_W must cover OFFS_W and the counter index");
   end

   logic [PC_W-1:0] pc_b;
   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] upd_target;
   logic            br0, br1;
   ctr_t            ctr0, ctr1;
   logic            hit0, hit1;
   logic [PC_W-1:0] tgt0, tgt1;

   assign pc_b = fetch_pc + PC_W'(1);
   assign br0  = (slot0_op == OP_BRANCH);
   assign br1  = (slot1_op == OP_BRANCH);

   if (PC_W == OFFS_W) begin : g_ext_same
      assign off_ext = upd_offset;
   end else begin : g_ext_wide
      assign off_ext = {{(PC_W - OFFS_W){upd_offset[OFFS_W-1]}}, upd_offset};
   end

   assign upd_target = upd_pc + PC_W'(1) + off_ext;

   bp_ctr_table #(.ENTRIES(CTR_ENTRIES)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx_a (fetch_pc[IDX_W-1:0]),
      .rd_idx_b (pc_b[IDX_W-1:0]),
      .wr_en    (upd_valid),
      .wr_idx   (upd_pc[IDX_W-1:0]),
      .wr_taken (upd_taken),
      .rd_ctr_a (ctr0),
      .rd_ctr_b (ctr1)
   );

   bp_target_buffer #(.ENTRIES(BTB_ENTRIES), .PC_W(PC_W)) u_btb (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_pc_a (fetch_pc),
      .look_pc_b (pc_b),
      .wr_en     (upd_valid),
      .wr_pc     (upd_pc),
      .wr_target (upd_target),
      .hit_a     (hit0),
      .tgt_a     (tgt0),
      .hit_b     (hit1),
      .tgt_b     (tgt1)
   );

   bp_group_trim #(.PC_W(PC_W), .PAIR_BR_TRIM(PAIR_BR_TRIM)) u_trim (
      .pc          (fetch_pc),
      .br0         (br0),
      .br1         (br1),
      .tk0         (br0 & ctr_says_taken(ctr0) & hit0),
      .tk1         (br1 & ctr_says_taken(ctr1) & hit1),
      .tgt0        (tgt0),
      .tgt1        (tgt1),
      .pred_taken  (pred_taken),
      .pred_target (pred_target),
      .fwd_two     (fwd_two),
      .next_pc     (next_pc)
   );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
   parameter int PC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [2:0]      slot0_op,
   input logic [2:0]      slot1_op,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_target,
   input logic            fwd_two,
   input logic [PC_W-1:0] next_pc
);

   logic s0_br, s1_br;
   assign s0_br = (slot0_op == 3'b100);
   assign s1_br = (slot1_op == 3'b100);

   assert_taken_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> next_pc == pred_target);

   assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (next_pc == fetch_pc + (fwd_two ? PC_W'(2) : PC_W'(1))
                       && pred_target == '0));

   assert_pair_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_br && s1_br) |-> !fwd_two);

   assert_slot0_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && s0_br) |-> !fwd_two);

   assert_no_branch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!s0_br && !s1_br) |-> (!pred_taken && fwd_two));

endmodule

bind branch_pred_unit bp_checker #(.PC_W(PC_W)) u_bp_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_pc    (fetch_pc),
   .slot0_op    (slot0_op),
   .slot1_op    (slot1_op),
   .pred_taken  (pred_taken),
   .pred_target (pred_target),
   .fwd_two     (fwd_two),
   .next_pc     (next_pc)
);

// File: tb/branch_pred_unit_test.sv
module branch_pred_unit_test;

   localparam logic [2:0] BR  = 3'b100;
   localparam logic [2:0] ADD = 3'b000;
   localparam logic [2:0] NOP = 3'b111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fetch_pc = '0;
   logic [2:0]  slot0_op = ADD;
   logic [2:0]  slot1_op = ADD;
   logic        upd_valid = 1'b0;
   logic [15:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [15:0] upd_offset = '0;
   logic        pred_taken;
   logic [15:0] pred_target;
   logic        fwd_two;
   logic [15:0] next_pc;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   branch_pred_unit uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_pc    (fetch_pc),
      .slot0_op    (slot0_op),
      .slot1_op    (slot1_op),
      .upd_valid   (upd_valid),
      .upd_pc      (upd_pc),
      .upd_taken   (upd_taken),
      .upd_offset  (upd_offset),
      .pred_taken  (pred_taken),
      .pred_target (pred_target),
      .fwd_two     (fwd_two),
      .next_pc     (next_pc)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n     = 1'b0;
      upd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic update(input logic [15:0] pc, input logic tk, input logic [15:0] off);
      @(negedge clk);
      upd_valid  = 1'b1;
      upd_pc     = pc;
      upd_taken  = tk;
      upd_offset = off;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic look(input logic [15:0] pc, input logic [2:0] op0, input logic [2:0] op1);
      @(negedge clk);
      fetch_pc = pc;
      slot0_op = op0;
      slot1_op = op1;
      #1;
   endtask

   task automatic expect_group(input string req, input logic tk, input logic two,
                               input logic [15:0] nxt, input logic [15:0] tgt);
      check(req, {31'd0, pred_taken}, {31'd0, tk});
      check(req, {31'd0, fwd_two}, {31'd0, two});
      check(req, {16'd0, next_pc}, {16'd0, nxt});
      check(req, {16'd0, pred_target}, {16'd0, tgt});
   endtask

   task automatic t_reset_state();
      do_reset();
      look(16'h0010, BR, ADD);
      expect_group("R1 fresh slot0 branch", 1'b0, 1'b1, 16'h0012, 16'h0);
      look(16'h0010, ADD, BR);
      expect_group("R1 fresh slot1 branch", 1'b0, 1'b1, 16'h0012, 16'h0);
   endtask

   task automatic t_first_taken();
      do_reset();
      update(16'h0010, 1'b1, 16'd5);
      look(16'h0010, BR, ADD);
      expect_group("R7 slot0 taken trims", 1'b1, 1'b0, 16'h0016, 16'h0016);
      look(16'h0050, BR, ADD);
      expect_group("R6 taken ctr but btb miss", 1'b0, 1'b1, 16'h0052, 16'h0);
      update(16'h0050, 1'b0, 16'd2);
      look(16'h0010, BR, ADD);
      expect_group("R3 alias lowered shared ctr", 1'b0, 1'b1, 16'h0012, 16'h0);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int k = 0; k < 4; k++) update(16'h0020, 1'b1, 16'd3);
      update(16'h0020, 1'b0, 16'd3);
      look(16'h0020, BR, ADD);
      expect_group("R2 top saturates", 1'b1, 1'b0, 16'h0024, 16'h0024);
      update(16'h0020, 1'b0, 16'd3);
      look(16'h0020, BR, ADD);
      expect_group("R2 down to weak nt", 1'b0, 1'b1, 16'h0022, 16'h0);
      for (int k = 0; k < 3; k++) update(16'h0020, 1'b0, 16'd3);
      update(16'h0020, 1'b1, 16'd3);
      look(16'h0020, BR, ADD);
      expect_group("R2 bottom saturates", 1'b0, 1'b1, 16'h0022, 16'h0);
      update(16'h0020, 1'b1, 16'd3);
      look(16'h0020, BR, ADD);
      expect_group("R2 up to weak taken", 1'b1, 1'b0, 16'h0024, 16'h0024);
   endtask

   task automatic t_not_taken_insert();
      do_reset();
      update(16'h0030, 1'b0, 16'd7);
      update(16'h0070, 1'b1, 16'hFFFC);
      update(16'h0070, 1'b1, 16'hFFFC);
      look(16'h0030, BR, ADD);
      expect_group("R4 not-taken branch was stored", 1'b1, 1'b0, 16'h0038, 16'h0038);
      look(16'h0070, BR, ADD);
      expect_group("R4 negative offset target", 1'b1, 1'b0, 16'h006D, 16'h006D);
   endtask

   task automatic t_lru();
      do_reset();
      update(16'h0001, 1'b1, 16'd9);
      update(16'h0002, 1'b1, 16'd9);
      update(16'h0003, 1'b1, 16'd9);
      update(16'h0001, 1'b1, 16'd9);
      update(16'h0004, 1'b1, 16'd9);
      look(16'h0002, BR, ADD);
      expect_group("R5 lru entry evicted", 1'b0, 1'b1, 16'h0004, 16'h0);
      look(16'h0001, BR, ADD);
      expect_group("R5 refreshed entry kept", 1'b1, 1'b0, 16'h000B, 16'h000B);
      for (int k = 0; k < 4; k++) look(16'h0003, BR, ADD);
      update(16'h0005, 1'b1, 16'd9);
      look(16'h0003, BR, ADD);
      expect_group("R5 lookups do not refresh", 1'b0, 1'b1, 16'h0005, 16'h0);
      look(16'h0001, BR, ADD);
      expect_group("R5 newer entry survives", 1'b1, 1'b0, 16'h000B, 16'h000B);
   endtask

   task automatic t_slots();
      do_reset();
      update(16'h0051, 1'b1, 16'd10);
      look(16'h0050, ADD, BR);
      expect_group("R9 slot1 taken", 1'b1, 1'b1, 16'h005C, 16'h005C);
      look(16'h0050, BR, ADD);
      expect_group("R9 slot0 not taken", 1'b0, 1'b1, 16'h0052, 16'h0);
      look(16'h0050, BR, BR);
      expect_group("R8 two branches trim", 1'b0, 1'b0, 16'h0051, 16'h0);
      look(16'h0050, ADD, NOP);
      expect_group("R11 no branch opcodes", 1'b0, 1'b1, 16'h0052, 16'h0);
      look(16'h0050, NOP, ADD);
      expect_group("R11 no branch opcodes b", 1'b0, 1'b1, 16'h0052, 16'h0);
   endtask

   task automatic t_same_cycle();
      do_reset();
      update(16'h0040, 1'b1, 16'd1);
      @(negedge clk);
      fetch_pc   = 16'h0040;
      slot0_op   = BR;
      slot1_op   = ADD;
      upd_valid  = 1'b1;
      upd_pc     = 16'h0040;
      upd_taken  = 1'b0;
      upd_offset = 16'd1;
      #1;
      expect_group("R10 old state during update", 1'b1, 1'b0, 16'h0042, 16'h0042);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      expect_group("R10 new state after update", 1'b0, 1'b1, 16'h0042, 16'h0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      t_reset_state();
      t_first_taken();
      t_saturate();
      t_not_taken_insert();
      t_lru();
      t_slots();
      t_same_cycle();
      finish_run();
   end

endmodule